// File: doc/BRIEF.md
# Multi-Channel Event Timer

This block is a memory-mapped event timer. A 64-bit main counter advances once per clock while software lets it run, and a small set of comparator channels watch it. A channel that reaches its comparator sets a status bit, and that bit drives an interrupt line until software clears it. A channel can fire once (one-shot) or rearm itself by adding a stored period to its comparator (periodic). It can also restrict the comparison to the low 32 bits, where the comparator wraps modulo 2^32.

Software reaches everything through a simple 32-bit register port: a write strobe, a read strobe, a 12-bit byte address and write data, with read data registered one clock after the read strobe. Global registers sit at fixed offsets: capabilities 0x000, tick period 0x004, global control 0x010, interrupt status 0x020, counter low word 0x0F0 and high word 0x0F4. Channel n occupies 0x100 + 0x20*n: control at +0x00, comparator low at +0x08, comparator high at +0x0C.

Interrupt delivery has two modes. Normally each channel drives the line its route field selects. With the legacy-replacement bit set, channel 0 drives a dedicated system-tick output and channel 1 drives a dedicated real-time-clock output, and neither drives the routed lines.

Top module: `event_timer`

## Requirements
- R1: While global control bit 0 (run) is 1 the counter increases by one each clock; while it is 0 the counter holds. Writes to 0x0F0 and 0x0F4 load the low and high halves, and the low half carries into the high half.
- R2: The capability register at 0x000 reads NUM_CH-1 in bits [4:0] and 1 in bit 8 (legacy mode supported); 0x004 reads the tick period TICK_FS in femtoseconds, which must lie between 100 fs and 100 ns.
- R3: A channel with control bit 0 (enable) set and bit 1 (periodic) clear sets its status bit once, in the clock where the running counter equals its comparator, and leaves its comparator unchanged.
- R4: A periodic channel adds its stored period to its comparator at each match.
- R5: A control write with bits 1 and 2 both set makes the next comparator-low write load the comparator and the one after it load the period; bit 2 always reads back as 0.
- R6: With control bit 3 (32-bit mode) set, only the low 32 bits of counter and comparator are compared, and a periodic reload wraps the low half modulo 2^32 and leaves the high half alone.
- R7: Status at 0x020 (bit n for channel n) is a level held until software writes 1 to that bit; writing 0 has no effect; a match in the same clock as the clear keeps the bit set.
- R8: Clearing a channel's enable bit drops its interrupt output on the next clock while its status bit stays set.
- R9: Each enabled channel with status set drives irq_o[route], route being control bits [4 +: log2(NUM_IRQ)]; routed lines are ORs of their channels and rise one clock after the status bit.
- R10: With global control bit 1 (legacy) set, channel 0 drives tick_irq_o and channel 1 drives rtc_irq_o instead of their routed lines; clearing the bit returns them to routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after bus_rd |
| tick_irq_o | output | 1 | System-tick interrupt (channel 0 in legacy mode) |
| rtc_irq_o | output | 1 | Real-time-clock interrupt (channel 1 in legacy mode) |
| irq_o | output | NUM_IRQ | Routed interrupt lines |

## Verification
The hardest situation to reach is a match in 32-bit mode across a carry of the low word, where the high halves of counter and comparator disagree. The stimulus presets the stopped counter just below a low-word wrap with a nonzero high half, arms a 32-bit periodic channel and a full-width channel on the same low value, then starts the counter: only the narrow channel may fire and its comparator must wrap. Random comparator values, periods and routes then confirm the exact firing clock against a bench model.

// File: rtl/et_pkg.sv
package et_pkg;
  localparam logic [11:0] A_CAPS = 12'h000;
  localparam logic [11:0] A_TICK = 12'h004;
  localparam logic [11:0] A_GCFG = 12'h010;
  localparam logic [11:0] A_STAT = 12'h020;
  localparam logic [11:0] A_CNTL = 12'h0F0;
  localparam logic [11:0] A_CNTH = 12'h0F4;
  localparam logic [3:0]  CH_PAGE = 4'h1;
  localparam logic [4:0]  O_CFG  = 5'h00;
  localparam logic [4:0]  O_CMPL = 5'h08;
  localparam logic [4:0]  O_CMPH = 5'h0C;
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_PER   = 1;
  localparam int unsigned B_SETV  = 2;
  localparam int unsigned B_N32   = 3;
  localparam int unsigned B_ROUTE = 4;
  typedef enum logic [1:0] {SV_IDLE, SV_CMP, SV_PER} sv_stage_e;
endpackage

// File: rtl/et_counter.sv
module et_counter (
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        lo_we,
  input  logic        hi_we,
  input  logic [31:0] wdata,
  output logic [63:0] count
);
  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (lo_we) count[31:0] <= wdata;
    else if (hi_we) count[63:32] <= wdata;
    else if (run)   count <= count + 64'd1;
  end

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !lo_we && !hi_we) |=> $stable(count));
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !lo_we && !hi_we) |=> (count == $past(count) + 64'd1));
endmodule

// File: rtl/et_channel.sv
module et_channel
  import et_pkg::*;
#(
  parameter int unsigned RT_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [63:0]     count,
  input  logic            cfg_we,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic            stat_clr,
  input  logic [31:0]     wdata,
  output logic            en,
  output logic [RT_W-1:0] route,
  output logic            stat,
  output logic [63:0]     cmp,
  output logic [31:0]     cfg_word
);
  logic        periodic, narrow, match, fire;
  logic [31:0] per_q;
  logic [63:0] cmp_reload;
  sv_stage_e   sv_q;

  always_comb begin
    match      = narrow ? (count[31:0] == cmp[31:0]) : (count == cmp);
    fire       = run && en && match;
    cmp_reload = narrow ? {cmp[63:32], cmp[31:0] + per_q} : cmp + {32'd0, per_q};
    cfg_word   = '0;
    cfg_word[B_EN]  = en;
    cfg_word[B_PER] = periodic;
    cfg_word[B_N32] = narrow;
    cfg_word[B_ROUTE +: RT_W] = route;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; periodic <= 1'b0; narrow <= 1'b0; route <= '0;
      cmp <= '1; per_q <= '0; sv_q <= SV_IDLE; stat <= 1'b0;
    end else begin
      if (cfg_we) begin
        en       <= wdata[B_EN];
        periodic <= wdata[B_PER];
        narrow   <= wdata[B_N32];
        route    <= wdata[B_ROUTE +: RT_W];
        if (wdata[B_PER] && wdata[B_SETV]) sv_q <= SV_CMP;
      end
      if (lo_we && sv_q == SV_PER) begin
        per_q <= wdata;
        sv_q  <= SV_IDLE;
      end
      if (lo_we && sv_q != SV_PER) begin
        cmp[31:0] <= wdata;
        if (sv_q == SV_CMP) sv_q <= SV_PER;
      end else if (hi_we) begin
        cmp[63:32] <= wdata;
      end else if (fire && periodic) begin
        cmp <= cmp_reload;
      end
      if (fire)          stat <= 1'b1;
      else if (stat_clr) stat <= 1'b0;
    end
  end

  // R3
  oneshot_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !periodic && !lo_we && !hi_we) |=> $stable(cmp));
  // R4
  period_add_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && periodic && !narrow && !lo_we && !hi_we) |=> (cmp == $past(cmp) + {32'd0, $past(per_q)}));
  // R6
  narrow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && periodic && narrow && !lo_we && !hi_we) |=> (cmp[63:32] == $past(cmp[63:32])));
  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat && !stat_clr) |=> stat);
endmodule

// File: rtl/et_irq_route.sv
module et_irq_route #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned RT_W    = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   legacy,
  input  logic [NUM_CH-1:0]      act,
  input  logic [NUM_CH*RT_W-1:0] route_flat,
  output logic                   tick_irq,
  output logic                   rtc_irq,
  output logic [NUM_IRQ-1:0]     lines
);
  logic [NUM_IRQ-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (act[c] && !(legacy && c < 2))
        nxt[route_flat[c*RT_W +: RT_W]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_irq <= 1'b0; rtc_irq <= 1'b0; lines <= '0;
    end else begin
      tick_irq <= legacy && act[0];
      rtc_irq  <= legacy && act[1];
      lines    <= nxt;
    end
  end

  // R10
  tick_src_chk: assert property (@(posedge clk) disable iff (rst)
    tick_irq |-> $past(legacy && act[0]));
  // R10
  rtc_src_chk: assert property (@(posedge clk) disable iff (rst)
    rtc_irq |-> $past(legacy && act[1]));
  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (act == '0) |=> (lines == '0 && !tick_irq && !rtc_irq));
endmodule

// File: rtl/event_timer.sv
module event_timer
  import et_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned TICK_FS = 4000000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               tick_irq_o,
  output logic               rtc_irq_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  localparam int unsigned RT_W = $clog2(NUM_IRQ);
  localparam int unsigned CI_W = $clog2(NUM_CH);

  logic                   run_q, legacy_q;
  logic [63:0]            count;
  logic                   ch_page;
  logic [2:0]             ch_idx;
  logic [4:0]             off;
  logic [NUM_CH-1:0]      stat_v, en_v;
  logic [NUM_CH*RT_W-1:0] route_flat;
  logic [63:0]            cmp_a   [NUM_CH];
  logic [31:0]            cfgw_a  [NUM_CH];
  logic [31:0]            rd_word;

  assign ch_page = (bus_addr[11:8] == CH_PAGE);
  assign ch_idx  = bus_addr[7:5];
  assign off     = bus_addr[4:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; legacy_q <= 1'b0;
    end else if (bus_wr && bus_addr == A_GCFG) begin
      run_q <= bus_wdata[0]; legacy_q <= bus_wdata[1];
    end
  end

  et_counter u_cnt (
    .clk(clk), .rst(rst), .run(run_q),
    .lo_we(bus_wr && bus_addr == A_CNTL),
    .hi_we(bus_wr && bus_addr == A_CNTH),
    .wdata(bus_wdata), .count(count)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = bus_wr && ch_page && (ch_idx == 3'(i));
    et_channel #(.RT_W(RT_W)) u_ch (
      .clk(clk), .rst(rst), .run(run_q), .count(count),
      .cfg_we(sel && off == O_CFG),
      .lo_we(sel && off == O_CMPL),
      .hi_we(sel && off == O_CMPH),
      .stat_clr(bus_wr && bus_addr == A_STAT && bus_wdata[i]),
      .wdata(bus_wdata),
      .en(en_v[i]), .route(route_flat[i*RT_W +: RT_W]), .stat(stat_v[i]),
      .cmp(cmp_a[i]), .cfg_word(cfgw_a[i])
    );
  end

  et_irq_route #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ), .RT_W(RT_W)) u_route (
    .clk(clk), .rst(rst), .legacy(legacy_q), .act(stat_v & en_v),
    .route_flat(route_flat), .tick_irq(tick_irq_o), .rtc_irq(rtc_irq_o), .lines(irq_o)
  );

  always_comb begin
    rd_word = '0;
    if (ch_page) begin
      if ({29'd0, ch_idx} < 32'(NUM_CH)) begin
        case (off)
          O_CFG:   rd_word = cfgw_a[ch_idx[CI_W-1:0]];
          O_CMPL:  rd_word = cmp_a[ch_idx[CI_W-1:0]][31:0];
          O_CMPH:  rd_word = cmp_a[ch_idx[CI_W-1:0]][63:32];
          default: rd_word = '0;
        endcase
      end
    end else begin
      case (bus_addr)
        A_CAPS:  begin rd_word[4:0] = 5'(NUM_CH - 1); rd_word[8] = 1'b1; end
        A_TICK:  rd_word = 32'(TICK_FS);
        A_GCFG:  rd_word = {30'd0, legacy_q, run_q};
        A_STAT:  rd_word = 32'(stat_v);
        A_CNTL:  rd_word = count[31:0];
        A_CNTH:  rd_word = count[63:32];
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: tb/event_timer_test.sv
`timescale 1ns/1ps
module event_timer_test;
  localparam int NUM_CH = 4;
  localparam int NUM_IRQ = 8;
  localparam int TICK_FS = 4000000;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tick_irq_o, rtc_irq_o;
  logic [NUM_IRQ-1:0] irq_o;
  int total = 0, bad = 0;
  int unsigned cyc = 0;
  bit done = 0;

  event_timer #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ), .TICK_FS(TICK_FS)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq_o(tick_irq_o),
    .rtc_irq_o(rtc_irq_o), .irq_o(irq_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] ch_a(int ch, int o);
    return 12'(32'h100 + 32'h20 * ch + o);
  endfunction
  function automatic logic [31:0] exp_cmp(logic [31:0] c, logic [31:0] p, bit per);
    return per ? c + p : c;
  endfunction
  function automatic logic [7:0] exp_mask(int route);
    return 8'(1 << route);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask
  task automatic restart();
    wr(12'h010, 32'h0);
    wr(12'h0F0, 32'h0);
    wr(12'h0F4, 32'h0);
    for (int c = 0; c < NUM_CH; c++) wr(ch_a(c, 0), 32'h0);
    wr(12'h020, 32'hFF);
  endtask
  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int unsigned e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(12'h010, d); chk("R1 reset gcfg", d, 0);
    rd(12'h020, d); chk("R7 reset status", d, 0);
    rd(12'h0F0, d); chk("R1 reset counter", d, 0);
    chk("R9 reset irq", {tick_irq_o, rtc_irq_o, irq_o}, 0);

    // R2 identification
    rd(12'h000, d); chk("R2 caps", d, 32'h100 | (NUM_CH - 1));
    rd(12'h004, d); chk("R2 tick period", d, TICK_FS);

    // R1 counting, holding, carry
    restart();
    wr(12'h010, 32'h1);
    rd(12'h0F0, d);  chk("R1 first read", d, 1);
    rd(12'h0F0, d);  chk("R1 second read", d, 3);
    wr(12'h010, 32'h0);
    rd(12'h0F0, d);  rd(12'h0F0, d2); chk("R1 hold", d2, d);
    wr(12'h0F0, 32'hFFFF_FFFE); wr(12'h0F4, 32'h0);
    wr(12'h010, 32'h1); wait_n(5);
    rd(12'h0F4, d);  chk("R1 carry into high", d, 1);

    // R3 one-shot, R9 routing, R7 level and clear
    restart();
    wr(ch_a(2, 0), 32'h31); wr(ch_a(2, 8), 32'd20); wr(ch_a(2, 12), 32'h0);
    wr(12'h010, 32'h1);
    wait_n(21); chk("R3 before match", irq_o, 0);
    wait_n(1);  chk("R9 route 3 on match", irq_o, exp_mask(3));
    wait_n(30); chk("R7 level held", irq_o, exp_mask(3));
    rd(ch_a(2, 8), d); chk("R3 comparator unchanged", d, 20);
    wr(12'h020, 32'h0); wait_n(1); chk("R7 write zero ignored", irq_o, exp_mask(3));
    wr(12'h020, 32'h4); wait_n(1); chk("R7 cleared output", irq_o, 0);
    rd(12'h020, d); chk("R7 status cleared", d, 0);

    // R5 set-value sequence, R4 periodic reload
    restart();
    wr(ch_a(3, 0), 32'h57); wr(ch_a(3, 8), 32'd30); wr(ch_a(3, 8), 32'd25);
    wr(ch_a(3, 12), 32'h0);
    rd(ch_a(3, 0), d); chk("R5 setval reads zero", d, 32'h53);
    rd(ch_a(3, 8), d); chk("R5 first write is comparator", d, 30);
    wr(12'h010, 32'h1); e = cyc;
    wait_n(31); chk("R4 before first", irq_o, 0);
    wait_n(1);  chk("R4 first expiry", irq_o, exp_mask(5));
    wr(12'h020, 32'h8);
    rd(ch_a(3, 8), d); chk("R4 comparator plus period", d, exp_cmp(30, 25, 1));
    while (cyc < e + 56) @(negedge clk);
    chk("R4 before second", irq_o, 0);
    wait_n(1); chk("R5 period used for second expiry", irq_o, exp_mask(5));
    rd(ch_a(3, 8), d); chk("R4 second reload", d, 80);

    // R6 32-bit mode across low-word wrap
    restart();
    wr(12'h0F4, 32'h1); wr(12'h0F0, 32'hFFFF_FFF0);
    wr(ch_a(1, 0), 32'h1F); wr(ch_a(1, 8), 32'hFFFF_FFF8); wr(ch_a(1, 8), 32'h10);
    wr(ch_a(1, 12), 32'h5);
    wr(ch_a(2, 0), 32'h21); wr(ch_a(2, 8), 32'hFFFF_FFF8); wr(ch_a(2, 12), 32'h5);
    wr(12'h010, 32'h1);
    wait_n(9); chk("R6 before match", irq_o, 0);
    wait_n(1); chk("R6 narrow fires, wide does not", irq_o, exp_mask(1));
    rd(ch_a(1, 8), d); chk("R6 low wraps", d, 32'h8);
    rd(ch_a(1, 12), d); chk("R6 high kept", d, 5);

    // R8 disable drops output, status kept
    wr(ch_a(1, 0), 32'h08); wait_n(1); chk("R8 output dropped", irq_o, 0);
    rd(12'h020, d); chk("R8 status kept", d & 32'h2, 32'h2);

    // R10 legacy replacement
    restart();
    wr(12'h010, 32'h2);
    wr(ch_a(0, 0), 32'h41); wr(ch_a(0, 8), 32'd10); wr(ch_a(0, 12), 32'h0);
    wr(ch_a(1, 0), 32'h41); wr(ch_a(1, 8), 32'd15); wr(ch_a(1, 12), 32'h0);
    wr(12'h010, 32'h3);
    wait_n(11); chk("R10 tick before", tick_irq_o, 0);
    wait_n(1);  chk("R10 tick fires", tick_irq_o, 1);
    chk("R10 routed line unused", irq_o, 0);
    wait_n(4);  chk("R10 rtc before", rtc_irq_o, 0);
    wait_n(1);  chk("R10 rtc fires", rtc_irq_o, 1);
    chk("R10 routed line still unused", irq_o, 0);
    wr(12'h010, 32'h1); wait_n(1);
    chk("R10 legacy off tick", {tick_irq_o, rtc_irq_o}, 0);
    chk("R9 legacy off routes ch0/1", irq_o, exp_mask(4));

    // random one-shot / periodic runs (R3 R4 R9)
    for (int it = 0; it < 8; it++) begin
      int ch = 2 + int'($urandom_range(1, 0));
      int c = int'($urandom_range(60, 6));
      int p = int'($urandom_range(80, 20));
      int rt = int'($urandom_range(7, 0));
      bit per = 1'($urandom_range(1, 0));
      restart();
      if (per) begin
        wr(ch_a(ch, 0), 32'h7 | (rt << 4)); wr(ch_a(ch, 8), c); wr(ch_a(ch, 8), p);
      end else begin
        wr(ch_a(ch, 0), 32'h1 | (rt << 4)); wr(ch_a(ch, 8), c);
      end
      wr(ch_a(ch, 12), 32'h0);
      wr(12'h010, 32'h1);
      wait_n(c + 1); chk("R9 random before", irq_o, 0);
      wait_n(1);     chk("R9 random fire", irq_o, exp_mask(rt));
      rd(ch_a(ch, 8), d); chk("R3 R4 random comparator", d, exp_cmp(c, p, per));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule